// File: doc/BRIEF.md
# Write-Triggered Joystick Port

This block replaces the four resistor-capacitor timers of a classic joystick port with clocked counters. When software writes to the port, four timing channels start together. Each channel output goes high and stays high for a number of clocks set by its axis position, with a fixed minimum added. It then drops back to zero. The value that software writes is never used.

Software measures an axis by reading the port repeatedly and counting how long each channel bit stays high. The same read byte also carries the state of two buttons for each of the two joysticks. A read only drives the data bus, and only a write starts the timers.

The bus side uses plain select, read and write strobes, and the read data comes with an enable. This is a register-style port with no data stream, so the block has no valid/ready handshake and no back-pressure. The read byte is valid for as long as the read strobe is held. The axis positions arrive as a packed vector, one 8-bit value per channel. The button inputs are active high (1 = pressed) and may change at any time.

Top module: `joy_port`

## Requirements
- R1: After reset, all four channel outputs are low, `rdata_en` is 0 and `rdata` is 0. A read with no buttons pressed then returns 8'hF0.
- R2: A write cycle is a rising edge of (`port_sel` & `wr_strobe`). All four channel bits go high in the clock cycle after the edge on which the write is sampled.
- R3: A channel stays high for exactly MIN_CNT + pos × SCALE clocks (64 + pos × 16 by default). Here pos is its 8-bit axis value, captured at the trigger edge. Later changes to the axis value do not alter a pulse that is already running.
- R4: A position of 0 gives a high time of exactly MIN_CNT clocks, and no channel is ever high for fewer than MIN_CNT clocks.
- R5: A write strobe held over several clocks triggers only once. The pulse is timed from the first sampled edge, whatever the length of the strobe.
- R6: A new write that arrives while channels are still high restarts all four channels. Each channel's pulse is then timed from the new trigger, using the positions captured at that new trigger.
- R7: While `port_sel` & `rd_strobe` are high and `wr_strobe` is low, `rdata_en` is 1 in the same cycle. The byte layout is: bit 0 = X1, bit 1 = Y1, bit 2 = X2, bit 3 = Y2. A read never starts the timers.
- R8: While `port_sel` is low, strobes have no effect. `rdata_en` stays 0, and a write without select starts no channel.
- R9: Bits 7..4 report the buttons in the order joystick 1 A, joystick 1 B, joystick 2 A, joystick 2 B. A button reads 0 while it is pressed and 1 while it is released, delayed by SYNC_STAGES clocks.
- R10: While `rdata_en` is 0, `rdata` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_sel | input | 1 | Port select from the address decoder |
| rd_strobe | input | 1 | Read strobe |
| wr_strobe | input | 1 | Write strobe; the written value is not used |
| axis_pos | input | 32 | Four 8-bit positions: [7:0] X1, [15:8] Y1, [23:16] X2, [31:24] Y2 |
| btn_pressed | input | 4 | Button inputs, 1 = pressed: [0] J1A, [1] J1B, [2] J2A, [3] J2B |
| rdata | output | 8 | Read byte: channel states in bits 3..0, button levels in bits 7..4 |
| rdata_en | output | 1 | High while the read byte is being driven |

## Verification
The assertions take two things for granted. First, read and write strobes are never asserted in the same cycle. Second, the bus inputs change only between active clock edges, so every write is seen as a single clean rising edge of select-and-write. The stimulus drives every input on the falling clock edge and always drops the write strobe before it raises the read strobe to poll. It holds the write strobe for several cycles only in the cases meant to show that one long strobe is one trigger. The minimum-width check counts clocks since the last trigger inside the checker, so a restart (R6) legitimately resets its window.

// File: rtl/joy_pkg.sv
package joy_pkg;

  // Number of counter bits needed to hold the longest pulse.
  function automatic int joy_cnt_width(input int min_cnt, input int scale, input int pos_w);
    int longest;
    longest = min_cnt + ((1 << pos_w) - 1) * scale;
    return $clog2(longest + 1);
  endfunction

  // Bit positions of the channels in the read byte.
  typedef enum int {
    CH_X1 = 0,
    CH_Y1 = 1,
    CH_X2 = 2,
    CH_Y2 = 3
  } joy_chan_e;

endpackage

// File: rtl/joy_bus_decode.sv
module joy_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic rd_i,
  input  logic wr_i,
  output logic fire_o,
  output logic rd_en_o
);

  logic wr_hit;
  logic wr_hit_q;

  assign wr_hit = sel_i & wr_i;

  // A held write counts once: fire only on the first sampled cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) wr_hit_q <= 1'b0;
    else        wr_hit_q <= wr_hit;
  end

  assign fire_o  = wr_hit & ~wr_hit_q;
  assign rd_en_o = sel_i & rd_i & ~wr_i;

endmodule

// File: rtl/joy_axis_timer.sv
module joy_axis_timer #(
  parameter int POS_W   = 8,
  parameter int SCALE   = 16,
  parameter int MIN_CNT = 64,
  parameter int CNT_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             busy_o
);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] load_val;

  // The length is fixed when the pulse starts; later position changes wait for the next start.
  assign load_val = CNT_W'(MIN_CNT) + CNT_W'(pos_i) * CNT_W'(SCALE);

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (start_i)        remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy_o = (remain != '0);

endmodule

// File: rtl/joy_btn_sync.sv
module joy_btn_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pressed_i,
  output logic [N-1:0] level_o
);

  logic [N-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pressed_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[s] <= '0;
        else        pipe[s] <= pipe[s-1];
      end
    end
  end

  // A pressed button reads as 0.
  assign level_o = ~pipe[STAGES-1];

endmodule

// File: rtl/joy_port.sv
module joy_port #(
  parameter int NUM_CH      = 4,
  parameter int NUM_BTN     = 4,
  parameter int POS_W       = 8,
  parameter int SCALE       = 16,
  parameter int MIN_CNT     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      port_sel,
  input  logic                      rd_strobe,
  input  logic                      wr_strobe,
  input  logic [NUM_CH*POS_W-1:0]   axis_pos,
  input  logic [NUM_BTN-1:0]        btn_pressed,
  output logic [NUM_CH+NUM_BTN-1:0] rdata,
  output logic                      rdata_en
);

  localparam int CNT_W  = joy_pkg::joy_cnt_width(MIN_CNT, SCALE, POS_W);
  localparam int DATA_W = NUM_CH + NUM_BTN;

  logic              fire;
  logic              rd_en;
  logic [NUM_CH-1:0] chan_state;
  logic [NUM_BTN-1:0] btn_level;

  joy_bus_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (port_sel),
    .rd_i    (rd_strobe),
    .wr_i    (wr_strobe),
    .fire_o  (fire),
    .rd_en_o (rd_en)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_axis
    joy_axis_timer #(
      .POS_W   (POS_W),
      .SCALE   (SCALE),
      .MIN_CNT (MIN_CNT),
      .CNT_W   (CNT_W)
    ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (fire),
      .pos_i   (axis_pos[c*POS_W +: POS_W]),
      .busy_o  (chan_state[c])
    );
  end

  joy_btn_sync #(
    .N      (NUM_BTN),
    .STAGES (SYNC_STAGES)
  ) u_btn (
    .clk       (clk),
    .rst_n     (rst_n),
    .pressed_i (btn_pressed),
    .level_o   (btn_level)
  );

  assign rdata_en = rd_en;
  assign rdata    = rd_en ? {btn_level, chan_state} : DATA_W'(0);

endmodule

// File: rtl/joy_port_chk.sv
module joy_port_chk #(
  parameter int NUM_CH  = 4,
  parameter int DATA_W  = 8,
  parameter int MIN_CNT = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_sel,
  input logic              rd_strobe,
  input logic              wr_strobe,
  input logic [NUM_CH-1:0] chan_state,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_en
);

  localparam int SW = $clog2(MIN_CNT + 2) + 1;

  logic              prev_wr;
  logic              prev_trig;
  logic [NUM_CH-1:0] prev_chan;
  logic [SW-1:0]     since;
  logic              trig_now;

  assign trig_now = port_sel && wr_strobe && !prev_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_wr   <= 1'b0;
      prev_trig <= 1'b0;
      prev_chan <= '0;
      since     <= '0;
    end else begin
      prev_wr   <= port_sel && wr_strobe;
      prev_trig <= trig_now;
      prev_chan <= chan_state;
      if (trig_now)               since <= SW'(1);
      else if (since != {SW{1'b1}}) since <= since + 1'b1;
    end
  end

  // R2
  trig_all_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_now |=> (chan_state == {NUM_CH{1'b1}}));

  // R8
  rise_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chan_state & ~prev_chan)) |-> prev_trig);

  // R4
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(prev_chan & ~chan_state)) |-> (since > SW'(MIN_CNT)));

  // R7
  read_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_sel && rd_strobe && !wr_strobe) |-> rdata_en);

  // R8
  no_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_sel |-> !rdata_en);

  // R7
  read_shows_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_en |-> (rdata[NUM_CH-1:0] == chan_state));

  // R10
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_en |-> (rdata == '0));

endmodule

bind joy_port joy_port_chk #(
  .NUM_CH  (NUM_CH),
  .DATA_W  (NUM_CH + NUM_BTN),
  .MIN_CNT (MIN_CNT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_sel   (port_sel),
  .rd_strobe  (rd_strobe),
  .wr_strobe  (wr_strobe),
  .chan_state (chan_state),
  .rdata      (rdata),
  .rdata_en   (rdata_en)
);

// File: tb/joy_port_test.sv
`timescale 1ns/1ps
module joy_port_test;

  localparam int T_MIN   = 64;
  localparam int T_SCALE = 16;
  localparam int T_SYNC  = 2;
  localparam int MAXW    = T_MIN + 255 * T_SCALE + 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_sel = 1'b0;
  logic        rd_strobe = 1'b0;
  logic        wr_strobe = 1'b0;
  logic [31:0] axis_pos = '0;
  logic [3:0]  btn_pressed = '0;
  logic [7:0]  rdata;
  logic        rdata_en;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  joy_port uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_sel    (port_sel),
    .rd_strobe   (rd_strobe),
    .wr_strobe   (wr_strobe),
    .axis_pos    (axis_pos),
    .btn_pressed (btn_pressed),
    .rdata       (rdata),
    .rdata_en    (rdata_en)
  );

  function automatic int exp_len(input logic [7:0] p);
    return T_MIN + int'(p) * T_SCALE;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse all channels and measure each high time by polling through the bus.
  task automatic measure(input logic [31:0] p, input int hold, input string req);
    int cnt [4];
    bit done [4];
    bit all_done;
    for (int i = 0; i < 4; i++) begin cnt[i] = 0; done[i] = 1'b0; end
    @(negedge clk);
    port_sel = 1'b1; wr_strobe = 1'b1; rd_strobe = 1'b0; axis_pos = p;
    for (int j = 1; j <= MAXW; j++) begin
      @(negedge clk);
      if (j == 2) axis_pos = $urandom;  // captured value must rule (R3)
      if (j <= hold) begin
        for (int i = 0; i < 4; i++) cnt[i]++;
      end else begin
        wr_strobe = 1'b0; rd_strobe = 1'b1;
        #1;
        all_done = 1'b1;
        for (int i = 0; i < 4; i++) begin
          if (!done[i]) begin
            if (rdata_en && rdata[i]) cnt[i]++;
            else done[i] = 1'b1;
          end
          all_done &= done[i];
        end
        if (all_done) break;
      end
    end
    rd_strobe = 1'b0; port_sel = 1'b0; wr_strobe = 1'b0;
    for (int i = 0; i < 4; i++)
      check(cnt[i] == exp_len(p[i*8 +: 8]), req, cnt[i], exp_len(p[i*8 +: 8]));
  endtask

  task automatic read_byte(output logic [7:0] v, output logic en);
    @(negedge clk);
    port_sel = 1'b1; rd_strobe = 1'b1; wr_strobe = 1'b0;
    #1;
    v = rdata; en = rdata_en;
    @(negedge clk);
    port_sel = 1'b0; rd_strobe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    logic       en;
    logic [3:0] pat;
    logic [31:0] rp;
    void'($urandom(32'd2718));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1
    check(rdata_en == 1'b0, "R1 en", rdata_en, 0);
    check(rdata == 8'h00, "R1 idle", rdata, 0);
    read_byte(v, en);
    check(v == 8'hF0, "R1 read", v, 8'hF0);

    // R2 R3 R4: directed positions including 0 and full scale
    measure({8'd255, 8'd128, 8'd1, 8'd0}, 0, "R3/R4 directed");
    measure({8'd0, 8'd0, 8'd0, 8'd0}, 0, "R4 minimum");
    measure({8'd7, 8'd200, 8'd33, 8'd90}, 0, "R2/R3 mixed");

    // R3 random positions, R5 random strobe length
    for (int k = 0; k < 5; k++) begin
      rp = $urandom;
      measure(rp, $urandom_range(0, 3), "R3/R5 random");
    end

    // R5 long held strobe, shorter than the shortest pulse
    measure({8'd3, 8'd2, 8'd1, 8'd0}, 40, "R5 held write");

    // R6 restart while running
    @(negedge clk);
    port_sel = 1'b1; wr_strobe = 1'b1; axis_pos = {4{8'd100}};
    repeat (50) begin
      @(negedge clk);
      wr_strobe = 1'b0; rd_strobe = 1'b1;
    end
    #1;
    check(rdata[3:0] == 4'hF, "R6 still running", rdata[3:0], 4'hF);
    measure({8'd5, 8'd60, 8'd0, 8'd17}, 0, "R6 restart");

    // R7 read alone never triggers
    @(negedge clk);
    port_sel = 1'b1; rd_strobe = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    check(rdata_en == 1'b1, "R7 enable", rdata_en, 1);
    check(rdata[3:0] == 4'h0, "R7 no trigger", rdata[3:0], 0);
    rd_strobe = 1'b0; port_sel = 1'b0;

    // R8 strobes without select
    @(negedge clk);
    wr_strobe = 1'b1;
    repeat (3) @(negedge clk);
    wr_strobe = 1'b0; rd_strobe = 1'b1;
    #1;
    check(rdata_en == 1'b0, "R8 rd no sel", rdata_en, 0);
    check(rdata == 8'h00, "R10 zero bus", rdata, 0);
    rd_strobe = 1'b0;
    read_byte(v, en);
    check(v[3:0] == 4'h0, "R8 wr no sel", v[3:0], 0);

    // R9 buttons, active-low reading after synchroniser
    for (int k = 0; k < 6; k++) begin
      pat = (k == 0) ? 4'hF : (k == 1) ? 4'h5 : 4'($urandom);
      @(negedge clk);
      btn_pressed = pat;
      repeat (T_SYNC + 1) @(negedge clk);
      read_byte(v, en);
      check(v[7:4] == ~pat, "R9 buttons", v[7:4], ~pat);
    end
    btn_pressed = '0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule